// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits between a memory array and the read port of a memory whose writes are self-timed. A programming timer raises a busy flag while a write runs. The responder watches the chip enable, output enable and write enable strobes. It also takes the busy flag, bit 7 of the last byte written, the address of that byte and the byte the array returns. While the memory is idle it passes the array byte through unchanged. While a write is running it overlays two completion indicators on the returned byte, so that a host can find out when the write ends without knowing how long the write takes.

The first indicator is an inverted copy of the most significant bit of the last written byte. It appears on bit 7 when the host reads the address that was written. The second indicator is bit 6, which flips once for every new read access, at any address. A read access starts when the read condition becomes true: chip enable low, output enable low and write enable high. Keeping that condition true does not start a new access. Bits 5 to 0 always carry array data. All inputs are sampled on the clock, and the output byte and its drive enable are registered, so they appear one clock after the inputs that produce them.

Top module: `wcs_responder`

## Requirements
- R1: While reset is applied, and for the two clocks after it is released, `rd_data_o` is 8'h00 and `rd_drive_o` is 0.
- R2: The read condition is `ce_n_i`=0, `oe_n_i`=0 and `we_n_i`=1. `rd_drive_o` equals the read condition one clock later. Whenever `rd_drive_o` is 0, `rd_data_o` is 8'h00.
- R3: When `wr_busy_i` is 0, an active read returns all eight bits of `arr_data_i` one clock later.
- R4: When `wr_busy_i` is 1 and `rd_addr_i` equals `last_addr_i`, bit 7 of the read byte is the inverse of `last_msb_i`. When the addresses differ, bit 7 is bit 7 of `arr_data_i`.
- R5: When `wr_busy_i` is 1, bit 6 of the read byte takes the opposite value from the previous access at the start of each new access. Its starting value is not defined, so only change or no change is meaningful.
- R6: While the read condition stays true across several clocks, bit 6 keeps its value.
- R7: Bits 5 to 0 of an active read are bits 5 to 0 of `arr_data_i`, whether or not a write is busy.
- R8: After `wr_busy_i` falls, bit 6 no longer toggles and the read byte equals `arr_data_i` on every access.
- R9: A new access, and so a flip of bit 6, can be started by raising and lowering `oe_n_i` alone or `ce_n_i` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| rd_addr_i | input | ADDR_W | Address of the current read |
| arr_data_i | input | 8 | Byte returned by the array for `rd_addr_i` |
| wr_busy_i | input | 1 | High while the programming timer runs |
| last_addr_i | input | ADDR_W | Address of the last byte written |
| last_msb_i | input | 1 | Bit 7 of the last byte written |
| rd_data_o | output | 8 | Registered read byte |
| rd_drive_o | output | 1 | Registered output drive enable |

## Verification
On every cycle the assertions check four things: the output is zero while it is not driven, an idle read passes the array byte, bits 5 to 0 follow the array, and bit 7 is inverted on a polled read of the written address. They also check that bit 6 holds while one access continues. That bit 6 really flips from one access to the next, including when the new access comes from only the chip enable or only the output enable, can be shown only by the bench's access sequences. The same holds for the end of toggling once busy falls. The bench's behavioural model is compared on every clock throughout.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  localparam int BYTE_W     = 8;
  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;
  localparam int ARR_BITS   = TOGGLE_BIT;  // bits below the toggle bit always follow the array

  typedef logic [BYTE_W-1:0] byte_t;

  // Merge status indicators into the array byte.
  function automatic byte_t merge_status(input byte_t arr, input logic busy,
                                         input logic hit, input logic msb_inv,
                                         input logic tog);
    byte_t r;
    r = arr;
    if (busy) begin
      r[TOGGLE_BIT] = tog;
      if (hit) r[POLL_BIT] = msb_inv;
    end
    return r;
  endfunction
endpackage

// File: rtl/wcs_reset_sync.sv
module wcs_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wcs_access_detect.sv
module wcs_access_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n_i,
  input  logic oe_n_i,
  input  logic we_n_i,
  output logic active_o,
  output logic start_o
);
  logic act_q;
  logic act_d;

  always_comb begin
    act_d    = ~ce_n_i & ~oe_n_i & we_n_i;
    active_o = act_d;
    start_o  = act_d & ~act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  // A new access cannot start on two clocks in a row (R6: holding adds no accesses)
  assert_single_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
endmodule

// File: rtl/wcs_toggle_state.sv
module wcs_toggle_state (
  input  logic clk,
  input  logic rst_n,
  input  logic advance_i,
  output logic tog_next_o
);
  logic tog_q;
  logic tog_d;

  always_comb begin
    tog_d = tog_q;
    if (advance_i) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tog_q <= 1'b0;
    else if (advance_i) tog_q <= tog_d;
  end

  assign tog_next_o = tog_d;
endmodule

// File: rtl/wcs_status_mux.sv
module wcs_status_mux
  import wcs_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              busy_i,
  input  logic              tog_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic              last_msb_i,
  input  byte_t             arr_data_i,
  output byte_t             rd_data_o,
  output logic              rd_drive_o
);
  byte_t data_q, data_d;
  logic  drive_q, drive_d;
  logic  hit;

  always_comb begin
    hit     = (rd_addr_i == last_addr_i);
    drive_d = active_i;
    data_d  = '0;
    if (active_i) data_d = merge_status(arr_data_i, busy_i, hit, ~last_msb_i, tog_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      drive_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      drive_q <= drive_d;
    end
  end

  assign rd_data_o  = data_q;
  assign rd_drive_o = drive_q;

  assert_idle_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !busy_i) |=> rd_data_o == $past(arr_data_i));

  assert_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |=> rd_data_o[ARR_BITS-1:0] == $past(arr_data_i[ARR_BITS-1:0]));

  assert_poll_invert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && busy_i && rd_addr_i == last_addr_i) |=> rd_data_o[POLL_BIT] != $past(last_msb_i));
endmodule

// File: rtl/wcs_responder.sv
module wcs_responder
  import wcs_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        arr_data_i,
  input  logic              wr_busy_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic              last_msb_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_drive_o
);
  logic rst_sync_n;
  logic active, start, tog_next;

  wcs_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  wcs_access_detect u_acc (
    .clk(clk), .rst_n(rst_sync_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
    .we_n_i(we_n_i), .active_o(active), .start_o(start));

  wcs_toggle_state u_tog (
    .clk(clk), .rst_n(rst_sync_n), .advance_i(start & wr_busy_i),
    .tog_next_o(tog_next));

  wcs_status_mux #(.ADDR_W(ADDR_W)) u_mux (
    .clk(clk), .rst_n(rst_sync_n), .active_i(active), .busy_i(wr_busy_i),
    .tog_i(tog_next), .rd_addr_i(rd_addr_i), .last_addr_i(last_addr_i),
    .last_msb_i(last_msb_i), .arr_data_i(arr_data_i),
    .rd_data_o(rd_data_o), .rd_drive_o(rd_drive_o));

  assert_undriven_zero_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_drive_o |-> rd_data_o == 8'h00);

  assert_drive_follows_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ce_n_i && !oe_n_i && we_n_i) |=> rd_drive_o);

  assert_hold_toggle_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_drive_o && !ce_n_i && !oe_n_i && we_n_i && wr_busy_i && $past(wr_busy_i))
      |=> rd_data_o[TOGGLE_BIT] == $past(rd_data_o[TOGGLE_BIT]));
endmodule

// File: tb/wcs_responder_test.sv
`timescale 1ns/1ps
module wcs_responder_test;
  localparam int AW = 17;
  localparam time TCLK = 20ns;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] rd_addr = '0, last_addr = '0;
  logic [7:0] arr = '0;
  logic busy = 0, last_msb = 0;
  logic [7:0] dout;
  logic drive;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  wcs_responder #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .rd_addr_i(rd_addr), .arr_data_i(arr), .wr_busy_i(busy),
    .last_addr_i(last_addr), .last_msb_i(last_msb),
    .rd_data_o(dout), .rd_drive_o(drive));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge
  int  rcnt = 0;
  bit  m_prev = 0, m_tog = 0, m_busy = 0;
  bit  m_en = 0;
  bit [7:0] m_dat = 0;
  always @(posedge clk) begin
    bit act;
    if (!rst_n) begin
      rcnt = 0; m_prev = 0; m_tog = 0; m_en = 0; m_dat = 0; m_busy = 0;
    end else if (rcnt < 2) begin
      rcnt++; m_prev = 0; m_tog = 0; m_en = 0; m_dat = 0; m_busy = 0;
    end else begin
      act = !ce_n && !oe_n && we_n;
      if (act && !m_prev && busy) m_tog = !m_tog;
      m_prev = act;
      m_en = act;
      m_busy = busy;
      m_dat = 0;
      if (act) begin
        m_dat = arr;
        if (busy) begin
          m_dat[6] = m_tog;
          if (rd_addr == last_addr) m_dat[7] = !last_msb;
        end
      end
    end
    #5;
    chk(drive == m_en, "R2 drive", drive, m_en);
    chk(dout[5:0] == m_dat[5:0], "R7 low bits", dout[5:0], m_dat[5:0]);
    chk(dout[6] == m_dat[6], m_busy ? "R5 toggle bit" : "R3 bit6", dout[6], m_dat[6]);
    chk(dout[7] == m_dat[7], m_busy ? "R4 poll bit" : "R3 bit7", dout[7], m_dat[7]);
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
    end
  end

  initial begin
    logic b6a, b6b, b6c;
    tick(3);
    chk(dout == 8'h00 && drive == 1'b0, "R1 reset", {drive, dout}, 0);
    rst_n = 1;
    tick(2);
    chk(dout == 8'h00 && drive == 1'b0, "R1 sync release", {drive, dout}, 0);
    tick(2);

    // Idle read passes array data
    rd_addr = 17'h00005; arr = 8'hC5; ce_n = 0; oe_n = 0;
    tick();
    chk(drive && dout == 8'hC5, "R3 idle read", dout, 8'hC5);
    oe_n = 1; tick();
    chk(!drive && dout == 8'h00, "R2 undriven", {drive, dout}, 0);

    // Write busy, poll written address (last msb 0)
    busy = 1; last_addr = 17'h01234; last_msb = 0;
    rd_addr = 17'h01234; arr = 8'h55; oe_n = 0;
    tick();
    chk(dout[7] == 1'b1, "R4 poll inverted", dout[7], 1);
    chk(dout[5:0] == 6'h15, "R7 low bits busy", dout[5:0], 6'h15);
    b6a = dout[6];
    oe_n = 1; tick(); oe_n = 0; tick();
    b6b = dout[6];
    chk(b6b != b6a, "R5 flip on new access", b6b, !b6a);
    tick(3);
    chk(dout[6] == b6b, "R6 hold no flip", dout[6], b6b);
    // chip enable only
    ce_n = 1; tick(); ce_n = 0; tick();
    b6c = dout[6];
    chk(b6c != b6b, "R9 chip-enable access", b6c, !b6b);
    // output enable only, again
    oe_n = 1; tick(); oe_n = 0; tick();
    chk(dout[6] == b6b, "R9 output-enable access", dout[6], b6b);

    // Other address: bit 7 from array
    rd_addr = 17'h00100; arr = 8'h2A; tick();
    chk(dout[7] == 1'b0 && dout[5:0] == 6'h2A, "R4 other address", dout, 8'h2A);

    // Last msb 1
    last_msb = 1; rd_addr = 17'h01234; arr = 8'hFF; tick();
    chk(dout[7] == 1'b0, "R4 poll msb one", dout[7], 0);

    // Write enable low blocks read
    we_n = 0; tick();
    chk(!drive && dout == 8'h00, "R2 write enable low", {drive, dout}, 0);
    we_n = 1; tick();

    // Write finished
    busy = 0; arr = 8'hB3; oe_n = 1; tick(); oe_n = 0; tick();
    chk(dout == 8'hB3, "R8 true data", dout, 8'hB3);
    oe_n = 1; tick(); oe_n = 0; tick();
    chk(dout == 8'hB3, "R8 no toggle", dout, 8'hB3);
    arr = 8'h4C; ce_n = 1; tick(); ce_n = 0; tick();
    chk(dout == 8'h4C, "R8 idle access", dout, 8'h4C);

    // Reset again mid-read
    rst_n = 0; tick();
    chk(dout == 8'h00 && !drive, "R1 reset mid read", {drive, dout}, 0);
    rst_n = 1; ce_n = 1; oe_n = 1; tick(4);

    done = 1;
    summary();
  end
endmodule